// File: doc/BRIEF.md
# Half-Length Spectrum Recombiner

This block rebuilds an N-point spectrum from the output of one N/2-point transform engine that is used twice per frame. The engine first delivers the spectrum of the even-indexed time samples and then the spectrum of the odd-indexed time samples. The block keeps the even spectrum in one N/2-deep buffer. As each odd bin arrives, it reads the matching even bin and forms the radix-2 pair: the lower bin X[k] goes straight out, and the upper bin X[k+N/2] is written back over the even entry it came from. After the lower half, the buffer is played back so that the output runs in natural bin order, one bin per clock.

The caller supplies the twiddle factor exp(-j2πk/N) for each odd bin on a separate port, in step with that bin. A parameter sets what happens while the buffer is being played back. In overlap mode the even spectrum of the next frame is taken in during playback, so frames follow each other back to back. In stall mode the input stays blocked until playback is over.

Top module: `halfspec_merge`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Accepted input samples alternate in groups of N/2: the first group is even-spectrum bins 0..N/2-1, the second is odd-spectrum bins 0..N/2-1. For odd bin k with twiddle W (signed, TW-1 fraction bits), X[k] = floor((E[k]·2^(TW-1) + O[k]·W) / 2^(TW-1)), per real and imaginary part in two's complement. It appears with `out_valid` high one clock after the edge that accepted odd bin k.
- R3: The upper bins X[k+N/2] = floor((E[k]·2^(TW-1) - O[k]·W) / 2^(TW-1)) follow the lower half in rising k, so each frame leaves in natural order 0..N-1. If the odd bins arrive without gaps, all N bins come out on N consecutive clocks.
- R4: `in_ready` is low in the clock right after the last odd bin is accepted. With OVERLAP=0 it stays low for all N/2 playback clocks. A sample presented while `in_ready` is low is not consumed.
- R5: With OVERLAP=1, even bins of the next frame are accepted during playback without corrupting the upper bins being played back. Under continuous input, the `out_last` pulses of successive frames are N+1 clocks apart.
- R6: Idle clocks (`in_valid` low) anywhere in the input stream change neither the values nor the order of the output bins.
- R7: `out_last` is high together with `out_valid`, and only for bin N-1 of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bin present |
| in_ready | output | 1 | Block accepts the input bin this clock |
| in_re | input | DW | Input bin, real part |
| in_im | input | DW | Input bin, imaginary part |
| tw_re | input | TW | Twiddle real part, used with odd bins |
| tw_im | input | TW | Twiddle imaginary part, used with odd bins |
| out_valid | output | 1 | Output bin present |
| out_last | output | 1 | Output bin is bin N-1 |
| out_re | output | DW+2 | Output bin, real part |
| out_im | output | DW+2 | Output bin, imaginary part |

## Verification
Several properties are checked on every clock: the quiet outputs after reset, the one-clock delay from an accepted odd bin to an output, the unbroken output during playback, the single write port never being claimed by an upper-bin write and an even-bin load in the same clock, and `out_last` never standing without `out_valid`. The bench scenarios are the only place where the arithmetic of both halves, the natural ordering, the exact position of `out_last`, the stall-mode ready pattern, tolerance of input gaps, and the N+1 spacing of back-to-back frames can be seen, because all of these need reference values worked out from the stimulus.

// File: rtl/halfspec_pkg.sv
package halfspec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOAD_EVEN = 2'd1,
    ST_COMBINE   = 2'd2,
    ST_DRAIN     = 2'd3
  } hs_state_t;
endpackage

// File: rtl/halfspec_buf.sv
// Simple dual-port buffer, read-first, registered read (block RAM friendly).
module halfspec_buf #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/halfspec_bfly.sv
// Radix-2 recombination of one bin pair: E +/- O*W, scaled back by 2^(TW-1).
module halfspec_bfly #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int OW = DW + 2
) (
  input  logic signed [OW-1:0] e_re,
  input  logic signed [OW-1:0] e_im,
  input  logic signed [DW-1:0] o_re,
  input  logic signed [DW-1:0] o_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [OW-1:0] lo_re,
  output logic signed [OW-1:0] lo_im,
  output logic signed [OW-1:0] hi_re,
  output logic signed [OW-1:0] hi_im
);
  localparam int SW = DW + TW + 2;

  logic signed [SW-1:0] ore_x, oim_x, wre_x, wim_x, ere_x, eim_x;
  logic signed [SW-1:0] p_re, p_im, s_lo_re, s_lo_im, s_hi_re, s_hi_im;

  always_comb begin
    ore_x   = {{(SW-DW){o_re[DW-1]}}, o_re};
    oim_x   = {{(SW-DW){o_im[DW-1]}}, o_im};
    wre_x   = {{(SW-TW){w_re[TW-1]}}, w_re};
    wim_x   = {{(SW-TW){w_im[TW-1]}}, w_im};
    ere_x   = {{(SW-OW){e_re[OW-1]}}, e_re} <<< (TW-1);
    eim_x   = {{(SW-OW){e_im[OW-1]}}, e_im} <<< (TW-1);
    p_re    = ore_x * wre_x - oim_x * wim_x;
    p_im    = ore_x * wim_x + oim_x * wre_x;
    s_lo_re = (ere_x + p_re) >>> (TW-1);
    s_lo_im = (eim_x + p_im) >>> (TW-1);
    s_hi_re = (ere_x - p_re) >>> (TW-1);
    s_hi_im = (eim_x - p_im) >>> (TW-1);
    lo_re   = OW'(s_lo_re);
    lo_im   = OW'(s_lo_im);
    hi_re   = OW'(s_hi_re);
    hi_im   = OW'(s_hi_im);
  end
endmodule

// File: rtl/halfspec_merge.sv
module halfspec_merge
  import halfspec_pkg::*;
#(
  parameter int NPTS    = 2048,
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter bit OVERLAP = 1'b1,
  localparam int HALF = NPTS / 2,
  localparam int AW   = $clog2(HALF),
  localparam int OW   = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic signed [TW-1:0] tw_re,
  input  logic signed [TW-1:0] tw_im,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  localparam logic [AW-1:0] LAST_IDX = AW'(HALF - 1);

  hs_state_t state;
  logic [AW-1:0] ecnt, ocnt, dcnt;
  logic          acc, even_we;

  // combine stage (one clock after an odd bin is accepted)
  logic                 s1_v;
  logic [AW-1:0]        s1_addr;
  logic signed [DW-1:0] s1_ore, s1_oim;
  logic signed [TW-1:0] s1_wre, s1_wim;
  // playback stage
  logic                 d1_v, d1_last;

  logic                 buf_we;
  logic [AW-1:0]        buf_wa, buf_ra;
  logic [2*OW-1:0]      buf_wd, buf_rd;
  logic signed [OW-1:0] rd_re, rd_im, lo_re, lo_im, hi_re, hi_im;

  always_comb begin
    in_ready = (state == ST_DRAIN) ? (OVERLAP && !s1_v) : 1'b1;
    acc      = in_valid && in_ready;
    even_we  = acc && (state != ST_COMBINE);
    buf_we   = s1_v || even_we;
    buf_wa   = s1_v ? s1_addr : ecnt;
    buf_wd   = s1_v ? {hi_re, hi_im}
                    : {{(OW-DW){in_re[DW-1]}}, in_re, {(OW-DW){in_im[DW-1]}}, in_im};
    buf_ra   = (state == ST_DRAIN) ? dcnt : ocnt;
    rd_re    = buf_rd[2*OW-1:OW];
    rd_im    = buf_rd[OW-1:0];
  end

  halfspec_buf #(.DEPTH(HALF), .WIDTH(2*OW)) u_buf (
    .clk(clk), .we(buf_we), .wa(buf_wa), .wd(buf_wd), .ra(buf_ra), .rd(buf_rd)
  );

  halfspec_bfly #(.DW(DW), .TW(TW), .OW(OW)) u_bfly (
    .e_re(rd_re), .e_im(rd_im), .o_re(s1_ore), .o_im(s1_oim),
    .w_re(s1_wre), .w_im(s1_wim),
    .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im)
  );

  // frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ecnt  <= '0;
      ocnt  <= '0;
      dcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_LOAD_EVEN: begin
          if (acc) begin
            ecnt <= ecnt + AW'(1);
            if (ecnt == LAST_IDX) begin
              state <= ST_COMBINE;
              ocnt  <= '0;
            end else begin
              state <= ST_LOAD_EVEN;
            end
          end
        end
        ST_COMBINE: begin
          if (acc) begin
            ocnt <= ocnt + AW'(1);
            if (ocnt == LAST_IDX) begin
              state <= ST_DRAIN;
              dcnt  <= '0;
            end
          end
        end
        default: begin
          dcnt <= dcnt + AW'(1);
          if (acc) ecnt <= ecnt + AW'(1);
          if (dcnt == LAST_IDX)
            state <= (acc || ecnt != '0) ? ST_LOAD_EVEN : ST_IDLE;
        end
      endcase
    end
  end

  // pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      d1_v    <= 1'b0;
      d1_last <= 1'b0;
    end else begin
      s1_v    <= acc && (state == ST_COMBINE);
      d1_v    <= (state == ST_DRAIN);
      d1_last <= (state == ST_DRAIN) && (dcnt == LAST_IDX);
    end
    s1_addr <= ocnt;
    s1_ore  <= in_re;
    s1_oim  <= in_im;
    s1_wre  <= tw_re;
    s1_wim  <= tw_im;
  end

  // registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= s1_v || d1_v;
      out_last  <= d1_v && d1_last;
    end
    out_re <= s1_v ? lo_re : rd_re;
    out_im <= s1_v ? lo_im : rd_im;
  end

  // ---------------- assertions ----------------
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !out_last);                               // R1
  AST_LOWER_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMBINE && in_valid && in_ready) |-> ##2 out_valid);      // R2
  AST_DRAIN_STREAM: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> ##2 out_valid);                                // R3
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(s1_v && even_we));                                                   // R4
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);                                               // R7
endmodule

// File: tb/halfspec_merge_test.sv
module halfspec_merge_test;
  localparam int N  = 16;
  localparam int H  = N / 2;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int OW = DW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic signed [TW-1:0] tw_re = '0, tw_im = '0;
  logic in_ready, out_valid, out_last;
  logic signed [OW-1:0] out_re, out_im;
  logic s_ready, s_valid, s_last;
  logic signed [OW-1:0] s_re, s_im;

  always #2.5 clk = ~clk;

  halfspec_merge #(.NPTS(N), .DW(DW), .TW(TW), .OVERLAP(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid), .out_last(out_last), .out_re(out_re), .out_im(out_im));

  halfspec_merge #(.NPTS(N), .DW(DW), .TW(TW), .OVERLAP(1'b0)) uut_s (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(s_ready),
    .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(s_valid), .out_last(s_last), .out_re(s_re), .out_im(s_im));

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // frame stimulus storage
  int ev_re[2][H], ev_im[2][H], od_re[2][H], od_im[2][H], wr[2][H], wi[2][H];
  int acc_cyc[2][H];

  // output monitor
  longint ob_re[64], ob_im[64];
  int ob_cyc[64];
  bit ob_last[64];
  int obn = 0;
  always @(negedge clk) begin
    if (!rst && out_valid && obn < 64) begin
      ob_re[obn]   = longint'(out_re);
      ob_im[obn]   = longint'(out_im);
      ob_cyc[obn]  = cyc;
      ob_last[obn] = out_last;
      obn++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_bin(int f, int k, bit upper, bit imag);
    longint p, e;
    p = imag ? (longint'(od_re[f][k]) * wi[f][k] + longint'(od_im[f][k]) * wr[f][k])
             : (longint'(od_re[f][k]) * wr[f][k] - longint'(od_im[f][k]) * wi[f][k]);
    e = longint'(imag ? ev_im[f][k] : ev_re[f][k]) * (longint'(1) <<< (TW-1));
    return (upper ? (e - p) : (e + p)) >>> (TW-1);
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic gen_frame(input int f);
    for (int k = 0; k < H; k++) begin
      ev_re[f][k] = rnd16(); ev_im[f][k] = rnd16();
      od_re[f][k] = rnd16(); od_im[f][k] = rnd16();
      wr[f][k]    = rnd16(); wi[f][k]    = rnd16();
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(input int re, input int im, input int twr, input int twi, output int c);
    in_valid = 1'b1;
    in_re = DW'(re); in_im = DW'(im); tw_re = TW'(twr); tw_im = TW'(twi);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    c = cyc;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int f, input bit gaps);
    int c;
    for (int k = 0; k < H; k++) begin
      if (gaps) repeat (k % 3) @(negedge clk);
      push(ev_re[f][k], ev_im[f][k], 0, 0, c);
    end
    for (int k = 0; k < H; k++) begin
      if (gaps) repeat ((k + 1) % 3) @(negedge clk);
      push(od_re[f][k], od_im[f][k], wr[f][k], wi[f][k], c);
      acc_cyc[f][k] = c;
    end
  endtask

  task automatic check_frame(input int f, input int base, input string req);
    for (int k = 0; k < N; k++) begin
      int kk = k % H;
      bit up = (k >= H);
      check({req, " re"}, ob_re[base+k], ref_bin(f, kk, up, 1'b0));
      check({req, " im"}, ob_im[base+k], ref_bin(f, kk, up, 1'b1));
      check("R7 last", longint'(ob_last[base+k]), longint'(k == N-1));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in_ready", longint'(in_ready), 1);
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 out_last", longint'(out_last), 0);
  endtask

  task automatic t_single();
    gen_frame(0);
    obn = 0;
    send_frame(0, 1'b0);
    // R4: ready pattern right after the last odd bin
    for (int i = 0; i <= H; i++) begin
      check("R4 ready overlap", longint'(in_ready), longint'(i != 0));
      check("R4 ready stall", longint'(s_ready), longint'(i == H));
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R3 count", obn, N);
    check_frame(0, 0, "R2R3 single");
    for (int k = 0; k < H; k++)
      check("R2 latency", ob_cyc[k], acc_cyc[0][k] + 1);
    for (int k = 0; k < N-1; k++)
      check("R3 contiguous", ob_cyc[k+1] - ob_cyc[k], 1);
  endtask

  task automatic t_gaps();
    gen_frame(0);
    obn = 0;
    send_frame(0, 1'b1);
    repeat (H + 6) @(negedge clk);
    check("R6 count", obn, N);
    check_frame(0, 0, "R6 gaps");
  endtask

  task automatic t_corner();
    for (int k = 0; k < H; k++) begin
      ev_re[0][k] = (k % 2) ? 32767 : -32768;
      ev_im[0][k] = -32768;
      od_re[0][k] = -32768; od_im[0][k] = (k % 2) ? 32767 : -32768;
      wr[0][k]    = -32768; wi[0][k]    = (k % 2) ? 32767 : -32768;
    end
    obn = 0;
    send_frame(0, 1'b0);
    repeat (H + 6) @(negedge clk);
    check("R3 corner count", obn, N);
    check_frame(0, 0, "R2R3 corner");
  endtask

  task automatic t_back_to_back();
    gen_frame(0);
    gen_frame(1);
    obn = 0;
    send_frame(0, 1'b0);
    send_frame(1, 1'b0);
    repeat (H + 6) @(negedge clk);
    check("R5 count", obn, 2 * N);
    check_frame(0, 0, "R5 frame0");
    check_frame(1, N, "R5 frame1");
    check("R5 spacing", ob_cyc[2*N-1] - ob_cyc[N-1], N + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_gaps();
    t_corner();
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule